// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block sits next to a processor's integer datapath. It owns a private pair of result registers, HI and LO, and runs iterative multiplies and divides on them. It performs signed and unsigned multiplication, where the 2*WIDTH-bit product lands with its upper half in HI and its lower half in LO. It performs signed and unsigned division, where the remainder goes to HI and the quotient to LO. It also serves the moves that copy a general operand into HI or LO, and the moves that read HI or LO back out for a register-file write.

Each multiply or divide resolves one operand bit per cycle. While an operation is in flight the unit reports `busy`. Requests enter on a valid/ready handshake, and a request transfers on a rising clock edge where both `req_valid` and `req_ready` are high. The unit lowers `req_ready` to back-pressure any new arithmetic request and any read of HI or LO until the result is written. A write to HI or LO that arrives during a computation is not stalled: it is taken and thrown away. Read data leaves on `rd_valid`/`rd_data` as a one-cycle pulse with no back-pressure, because the consumer is a register-file write port that always has room. Stall logic elsewhere watches `busy`.

Top module: `muldiv_hilo`

## Requirements
- R1: Code 0x18 multiplies `req_rs` by `req_rt` as two's-complement values and code 0x19 multiplies them as unsigned values. The product's upper WIDTH bits are written to HI and its lower WIDTH bits to LO.
- R2: Code 0x1A divides `req_rs` by `req_rt` as signed values and code 0x1B divides them as unsigned values. The quotient truncates toward zero and goes to LO. The remainder carries the dividend's sign and goes to HI. For the most negative dividend over -1, the quotient wraps to the most negative value.
- R3: When the divisor is zero, either divide finishes normally with LO all ones and HI equal to the dividend.
- R4: `busy` rises on the cycle after an arithmetic request is accepted and stays high for exactly WIDTH+1 cycles. It never rises for any other reason.
- R5: While `busy` is high, `req_ready` is low for arithmetic codes and for read codes (0x10, 0x12). Such a request waits and is accepted once `busy` drops, and a read accepted then returns the newly computed result.
- R6: An accepted read, with code 0x10 for HI or code 0x12 for LO, raises `rd_valid` for one cycle on the following cycle with the register value on `rd_data`. `rd_valid` is low at all other times.
- R7: When idle, code 0x11 writes `req_rs` into HI and code 0x13 writes `req_rs` into LO. The new value is visible to the next read.
- R8: A write code (0x11 or 0x13) presented while `busy` is high is accepted at once and changes neither HI nor LO.
- R9: After reset, HI and LO are zero, and `busy` and `rd_valid` are low.
- R10: Any code not listed above is accepted at once, has no effect on HI, LO or `busy`, and produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_func | input | 6 | Operation code |
| req_rs | input | WIDTH | First operand; also the value for writes to HI or LO |
| req_rt | input | WIDTH | Second operand (multiplier or divisor) |
| busy | output | 1 | Multiply or divide in flight |
| rd_valid | output | 1 | One-cycle pulse carrying read data |
| rd_data | output | WIDTH | Value of HI or LO for an accepted read |

## Verification
A corrupted shift register, a bad sign correction or a wrong step count never shows up while the operation runs. It appears only when HI or LO is read back, one cycle after the first read that `busy` lets through, as a wrong `rd_data`. A step counter that is off changes the width of the `busy` window at once and also leaves a misaligned product or quotient. The bench therefore reads both halves straight after every multiply and divide over all operand pairs of a 4-bit build. It also measures the busy window directly and uses reads to observe writes that should have been dropped.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [5:0] FN_RD_HI  = 6'h10;
  localparam logic [5:0] FN_WR_HI  = 6'h11;
  localparam logic [5:0] FN_RD_LO  = 6'h12;
  localparam logic [5:0] FN_WR_LO  = 6'h13;
  localparam logic [5:0] FN_MUL_S  = 6'h18;
  localparam logic [5:0] FN_MUL_U  = 6'h19;
  localparam logic [5:0] FN_DIV_S  = 6'h1A;
  localparam logic [5:0] FN_DIV_U  = 6'h1B;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} md_state_e;

  typedef struct packed {
    logic is_div;
    logic neg_a;
    logic neg_b;
    logic b_zero;
  } md_op_t;

  function automatic logic fn_is_arith(input logic [5:0] f);
    return (f == FN_MUL_S) || (f == FN_MUL_U) || (f == FN_DIV_S) || (f == FN_DIV_U);
  endfunction

  function automatic logic fn_is_read(input logic [5:0] f);
    return (f == FN_RD_HI) || (f == FN_RD_LO);
  endfunction

  function automatic logic fn_is_write(input logic [5:0] f);
    return (f == FN_WR_HI) || (f == FN_WR_LO);
  endfunction

  function automatic logic fn_is_signed(input logic [5:0] f);
    return (f == FN_MUL_S) || (f == FN_DIV_S);
  endfunction

endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod
);
  logic [W-1:0] mcand;
  logic [W:0]   sum;

  // add the multiplicand into the upper half when the current multiplier bit is set
  always_comb begin
    sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mcand} : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
      prod  <= '0;
    end else if (load) begin
      mcand <= mcand_in;
      prod  <= {{W{1'b0}}, mplier_in};
    end else if (step) begin
      prod <= {sum, prod[W-1:1]};
    end
  end
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend_in,
  input  logic [W-1:0] divisor_in,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] dsor;
  logic [W:0]   shifted;
  logic [W:0]   diff;

  // restoring step: bring in the next dividend bit, try to subtract
  always_comb begin
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dsor};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsor <= '0;
      quo  <= '0;
      rem  <= '0;
    end else if (load) begin
      dsor <= divisor_in;
      quo  <= dividend_in;
      rem  <= '0;
    end else if (step) begin
      if (!diff[W]) begin
        rem <= diff[W-1:0];
        quo <= {quo[W-2:0], 1'b1};
      end else begin
        rem <= shifted[W-1:0];
        quo <= {quo[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [5:0]       req_func,
  input  logic [WIDTH-1:0] req_rs,
  input  logic [WIDTH-1:0] req_rt,
  output logic             busy,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  md_state_e        state;
  md_op_t           op;
  logic [CNT_W-1:0] step_cnt;
  logic [WIDTH-1:0] hi_q, lo_q;

  logic             accept, idle, start, run;
  logic             neg_a, neg_b;
  logic [WIDTH-1:0] mag_a, mag_b;
  logic [2*WIDTH-1:0] prod_raw, prod_fix;
  logic [WIDTH-1:0] quo_raw, rem_raw, quo_fix, rem_fix;

  assign idle      = (state == ST_IDLE);
  assign run       = (state == ST_RUN);
  assign busy      = !idle;
  assign req_ready = idle || !(fn_is_arith(req_func) || fn_is_read(req_func));
  assign accept    = req_valid && req_ready;
  assign start     = accept && idle && fn_is_arith(req_func);

  // operand magnitudes for the unsigned cores
  always_comb begin
    neg_a = fn_is_signed(req_func) && req_rs[WIDTH-1];
    neg_b = fn_is_signed(req_func) && req_rt[WIDTH-1];
    mag_a = neg_a ? ('0 - req_rs) : req_rs;
    mag_b = neg_b ? ('0 - req_rt) : req_rt;
  end

  muldiv_mul_core #(.W(WIDTH)) mul_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .step      (run),
    .mcand_in  (mag_a),
    .mplier_in (mag_b),
    .prod      (prod_raw)
  );

  muldiv_div_core #(.W(WIDTH)) div_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (start),
    .step        (run),
    .dividend_in (mag_a),
    .divisor_in  (mag_b),
    .quo         (quo_raw),
    .rem         (rem_raw)
  );

  // sign correction applied in the final cycle
  always_comb begin
    prod_fix = (op.neg_a ^ op.neg_b) ? ('0 - prod_raw) : prod_raw;
    if (op.b_zero)
      quo_fix = '1;
    else
      quo_fix = (op.neg_a ^ op.neg_b) ? ('0 - quo_raw) : quo_raw;
    rem_fix = op.neg_a ? ('0 - rem_raw) : rem_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op       <= '0;
      step_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_RUN;
          step_cnt  <= '0;
          op.is_div <= (req_func == FN_DIV_S) || (req_func == FN_DIV_U);
          op.neg_a  <= neg_a;
          op.neg_b  <= neg_b;
          op.b_zero <= (req_rt == '0);
        end
        ST_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (state == ST_FIX) begin
      if (op.is_div) begin
        hi_q <= rem_fix;
        lo_q <= quo_fix;
      end else begin
        {hi_q, lo_q} <= prod_fix;
      end
    end else if (accept && idle) begin
      if (req_func == FN_WR_HI) hi_q <= req_rs;
      if (req_func == FN_WR_LO) lo_q <= req_rs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= accept && fn_is_read(req_func);
      if (accept && fn_is_read(req_func))
        rd_data <= (req_func == FN_RD_HI) ? hi_q : lo_q;
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [5:0] req_func,
  input logic       busy,
  input logic       rd_valid
);
  localparam int LEN_W = $clog2(WIDTH + 2) + 1;
  logic [LEN_W-1:0] run_len;
  logic             known;

  assign known = fn_is_arith(req_func) || fn_is_read(req_func) || fn_is_write(req_func);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready && fn_is_arith(req_func)));

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_len != '0) |-> (run_len == LEN_W'(WIDTH + 1)));

  // R4
  busy_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len <= LEN_W'(WIDTH)));

  // R5
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && (fn_is_arith(req_func) || fn_is_read(req_func))) |-> !req_ready);

  // R6
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && req_ready && fn_is_read(req_func)));

  // R8
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && fn_is_write(req_func)) |-> req_ready);

  // R10
  other_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !known) |-> req_ready);

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_func  (req_func),
  .busy      (busy),
  .rd_valid  (rd_valid)
);

// File: tb/muldiv_hilo_tb_top.sv
module muldiv_hilo_tb_top;
  localparam int W = 4;
  localparam logic [5:0] C_RHI = 6'h10, C_WHI = 6'h11, C_RLO = 6'h12, C_WLO = 6'h13;
  localparam logic [5:0] C_MS = 6'h18, C_MU = 6'h19, C_DS = 6'h1A, C_DU = 6'h1B;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [5:0]   req_func = '0;
  logic [W-1:0] req_rs = '0, req_rt = '0;
  logic         busy, rd_valid;
  logic [W-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  muldiv_hilo #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_func(req_func), .req_rs(req_rs), .req_rt(req_rt),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // presents a request, waits for the handshake, returns at the next falling edge
  task automatic issue(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_func = f; req_rs = a; req_rt = b;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [5:0] f, output logic ok, output logic [W-1:0] val);
    issue(f, '0, '0);
    ok  = rd_valid;
    val = rd_data;
  endtask

  function automatic longint ext(input logic [W-1:0] v, input logic sgn);
    if (sgn && v[W-1]) return longint'(v) - (longint'(1) << W);
    return longint'(v);
  endfunction

  task automatic expect_op(input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] ehi, output logic [W-1:0] elo);
    logic sg;
    longint x, y, r;
    logic [63:0] p;
    sg = (f == C_MS) || (f == C_DS);
    x = ext(a, sg);
    y = ext(b, sg);
    if (f == C_MS || f == C_MU) begin
      p = 64'(x * y);
      ehi = p[2*W-1 -: W];
      elo = p[W-1:0];
    end else if (b == '0) begin
      ehi = a;
      elo = '1;
    end else begin
      r = x / y;
      p = 64'(r);
      elo = p[W-1:0];
      r = x % y;
      p = 64'(r);
      ehi = p[W-1:0];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic ok;
    logic [W-1:0] v, ehi, elo;
    logic [5:0] ops [4];
    int n;
    ops[0] = C_MS; ops[1] = C_MU; ops[2] = C_DS; ops[3] = C_DU;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(rd_valid == 1'b0, "R9 rd_valid after reset", rd_valid, 0);
    read_reg(C_RHI, ok, v);
    chk(ok && v == '0, "R9 HI after reset", v, 0);
    read_reg(C_RLO, ok, v);
    chk(ok && v == '0, "R9 LO after reset", v, 0);

    // R7 writes then reads
    issue(C_WHI, 4'hA, '0);
    issue(C_WLO, 4'h5, '0);
    read_reg(C_RHI, ok, v);
    chk(ok && v == 4'hA, "R7 write HI", v, 4'hA);
    read_reg(C_RLO, ok, v);
    chk(ok && v == 4'h5, "R7 write LO", v, 4'h5);
    // R6 pulse lasts one cycle
    @(negedge clk);
    chk(rd_valid == 1'b0, "R6 rd_valid single cycle", rd_valid, 0);

    // R10 unknown code ignored
    issue(6'h20, 4'h3, 4'h3);
    chk(busy == 1'b0 && rd_valid == 1'b0, "R10 no busy or read pulse", {busy, rd_valid}, 0);
    read_reg(C_RHI, ok, v);
    chk(ok && v == 4'hA, "R10 HI unchanged", v, 4'hA);
    read_reg(C_RLO, ok, v);
    chk(ok && v == 4'h5, "R10 LO unchanged", v, 4'h5);

    // R4 busy window for a multiply and a divide
    foreach (ops[k]) begin
      if (k == 0 || k == 2) begin
        issue(ops[k], 4'h7, 4'h3);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        chk(n == W + 1, "R4 busy length", n, W + 1);
      end
    end

    // R8 write during computation is dropped
    issue(C_MU, 4'hF, 4'hF);
    chk(busy == 1'b1, "R8 busy before write", busy, 1);
    issue(C_WHI, 4'h2, '0);
    chk(busy == 1'b1, "R8 write accepted while busy", busy, 1);
    issue(C_WLO, 4'h2, '0);
    read_reg(C_RHI, ok, v);
    chk(ok && v == 4'hE, "R8 HI keeps product", v, 4'hE);
    read_reg(C_RLO, ok, v);
    chk(ok && v == 4'h1, "R8 LO keeps product", v, 4'h1);

    // R1 R2 R3 R5 exhaustive sweep; each read is issued while busy and held off
    foreach (ops[k]) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          expect_op(ops[k], W'(a), W'(b), ehi, elo);
          issue(ops[k], W'(a), W'(b));
          read_reg(C_RHI, ok, v);
          if (k < 2) chk(ok && v == ehi, "R1 R5 product high", v, ehi);
          else if (b == 0) chk(ok && v == ehi, "R3 R5 zero divisor remainder", v, ehi);
          else chk(ok && v == ehi, "R2 R5 remainder", v, ehi);
          read_reg(C_RLO, ok, v);
          if (k < 2) chk(ok && v == elo, "R1 product low", v, elo);
          else if (b == 0) chk(ok && v == elo, "R3 zero divisor quotient", v, elo);
          else chk(ok && v == elo, "R2 quotient", v, elo);
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule